// File: doc/BRIEF.md
# SPI Master Burst-Length Shifter

This block is the transmit/receive engine of an SPI master. One start request produces exactly one burst: chip select goes low, a programmed number of bits is clocked out on MOSI while the same number is clocked in from MISO, and chip select returns high. The bit count comes from a 12-bit length field holding the count minus one. A burst therefore covers from 1 to 4096 bits.

Data arrives as 32-bit words from a transmit FIFO with a show-ahead read port, and received data leaves as 32-bit words into a receive FIFO. Every word pulled from the transmit FIFO is loaded whole. When the bit count is not a multiple of 32, the first word gives only its low-order remainder bits and the rest of that word is dropped. All later words are sent in full. Bits go out MSB-first from the highest valid position. SPI mode 0 is used: SCLK idles low, data changes on the falling edge and is sampled on the rising edge. SCLK runs at the system clock divided by an even parameter.

At a word boundary the engine waits with SCLK held low and chip select still asserted if the transmit FIFO has nothing to give or the receive FIFO has no room.

Top module: `spi_burst_master`

## Requirements
- R1: A burst with length field L produces exactly L+1 rising SCLK edges. Chip select (active low) stays low from before the first edge until after the last, and SCLK is never high while chip select is high.
- R2: The first word of a burst sends only its (L mod 32)+1 least significant bits, starting at bit (L mod 32) and going down to bit 0. Its higher bits never reach MOSI.
- R3: After the first word, floor(L/32) further words are each sent in full, from bit 31 down to bit 0.
- R4: The transmit FIFO is popped (one-cycle tx_rd pulse) exactly once per word, floor(L/32)+1 times per burst, and only while it reports non-empty.
- R5: After the final bit of each word, one received word is pushed with a one-cycle rx_wr pulse. The first bit received for that word sits highest and the last sits in bit 0. The first word holds (L mod 32)+1 bits and its upper bits are zero.
- R6: If the transmit FIFO is empty at a word boundary, SCLK stops low and chip select stays low. The burst resumes with the next word once data arrives.
- R7: No push occurs while rx_full is high. At the end of a word the engine waits with SCLK low and chip select asserted until there is room.
- R8: start is accepted only while idle. A start pulse during a burst changes neither the bit count nor the data of that burst, and it does not trigger another burst.
- R9: done is high for exactly one cycle. That cycle is the one right after chip select returns high.
- R10: SCLK is high for CLK_DIV/2 system cycles per pulse, and MOSI does not change while SCLK is high.
- R11: During and right after reset, chip select is high, SCLK is low, and done, busy, tx_rd and rx_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (sampled only when idle) |
| burst_len | input | LEN_W | Bit count minus one |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse after chip select releases |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO has no word |
| tx_rd | output | 1 | Pop the transmit FIFO head |
| rx_data | output | 32 | Received word, valid with rx_wr |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_wr | output | 1 | Push rx_data into the receive FIFO |
| sclk | output | 1 | SPI serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can fall on the same word boundary. One is the push of the finished received word. The other is the load of the next transmit word, and either can meet a FIFO that is not ready. The bench provokes each case on its own. In one burst it leaves the transmit FIFO with only the first word. In another it holds rx_full high from the start. The check is that the rising-edge count freezes at exactly the first word's bit count, chip select stays low and no push appears. After the FIFO is released, the MOSI stream, the received words and the total edge count must all come out as if no stall had happened.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int BIT_W  = IDX_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_PUSH,
    ST_FINISH
  } burst_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(HALF) + 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(HALF - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [BIT_W-1:0]  load_bits,
  input  logic              shift_out,
  input  logic              sample_in,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-1:0] rx_sr;
  logic [BIT_W-1:0]  align;
  logic [WORD_W-1:0] aligned;

  // move the highest valid bit up to the MSB so shifting left drops the rest
  assign align   = BIT_W'(WORD_W) - load_bits;
  assign aligned = load_word << align[IDX_W-1:0];
  assign rx_word = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
      mosi  <= 1'b0;
    end else begin
      if (load) begin
        tx_sr <= aligned;
        mosi  <= aligned[WORD_W-1];
        rx_sr <= '0;
      end else begin
        if (shift_out) begin
          tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
          mosi  <= tx_sr[WORD_W-2];
        end
        if (sample_in) begin
          rx_sr <= {rx_sr[WORD_W-2:0], miso};
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             tick,
  output logic             run,
  output logic             load,
  output logic [BIT_W-1:0] load_bits,
  output logic             shift_out,
  output logic             sample_in,
  output logic             tx_rd,
  output logic             rx_wr,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int WCNT_W = LEN_W - IDX_W;

  burst_state_t      state;
  logic [WCNT_W-1:0] words_left;
  logic [BIT_W-1:0]  next_bits;
  logic [BIT_W-1:0]  bits_left;

  assign run       = (state == ST_SHIFT);
  assign load      = (state == ST_LOAD) && !tx_empty;
  assign load_bits = next_bits;
  assign sample_in = run && tick && !sclk;
  assign shift_out = run && tick && sclk;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      words_left <= '0;
      next_bits  <= '0;
      bits_left  <= '0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      tx_rd      <= 1'b0;
      rx_wr      <= 1'b0;
      done       <= 1'b0;
    end else begin
      tx_rd <= 1'b0;
      rx_wr <= 1'b0;
      done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            words_left <= burst_len[LEN_W-1:IDX_W];
            next_bits  <= BIT_W'(burst_len[IDX_W-1:0]) + BIT_W'(1);
            cs_n       <= 1'b0;
            state      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!tx_empty) begin
            tx_rd     <= 1'b1;
            bits_left <= next_bits;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk      <= 1'b0;
              bits_left <= bits_left - BIT_W'(1);
              if (bits_left == BIT_W'(1)) begin
                state <= ST_PUSH;
              end
            end
          end
        end
        ST_PUSH: begin
          if (!rx_full) begin
            rx_wr <= 1'b1;
            if (words_left != '0) begin
              words_left <= words_left - WCNT_W'(1);
              next_bits  <= BIT_W'(WORD_W);
              state      <= ST_LOAD;
            end else begin
              cs_n  <= 1'b1;
              state <= ST_FINISH;
            end
          end
        end
        ST_FINISH: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              busy,
  output logic              done,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  output logic              tx_rd,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_full,
  output logic              rx_wr,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic             run;
  logic             tick;
  logic             load;
  logic [BIT_W-1:0] load_bits;
  logic             shift_out;
  logic             sample_in;

  spi_half_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  spi_burst_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .burst_len (burst_len),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .tick      (tick),
    .run       (run),
    .load      (load),
    .load_bits (load_bits),
    .shift_out (shift_out),
    .sample_in (sample_in),
    .tx_rd     (tx_rd),
    .rx_wr     (rx_wr),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done)
  );

  spi_word_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (tx_data),
    .load_bits (load_bits),
    .shift_out (shift_out),
    .sample_in (sample_in),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic tx_empty,
  input logic tx_rd,
  input logic rx_full,
  input logic rx_wr,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);
  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (cs_n && !sclk && !done && !busy && !tx_rd && !rx_wr));

  assert_sclk_inside_cs_R1: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
    tx_rd |-> !$past(tx_empty));

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    rx_wr |-> !$past(rx_full));

  assert_done_after_cs_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_mosi_steady_R10: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .tx_empty (tx_empty),
  .tx_rd    (tx_rd),
  .rx_full  (rx_full),
  .rx_wr    (rx_wr),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .mosi     (mosi)
);

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  localparam int LEN_W   = 12;
  localparam int CLK_DIV = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [LEN_W-1:0] burst_len = '0;
  logic             busy, done, tx_rd, rx_wr, sclk, cs_n, mosi;
  logic [31:0]      tx_data = '0;
  logic             tx_empty = 1'b1;
  logic [31:0]      rx_data;
  logic             rx_full = 1'b0;
  logic             miso = 1'b0;

  spi_burst_master #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst(rst), .start(start), .burst_len(burst_len),
    .busy(busy), .done(done), .tx_data(tx_data), .tx_empty(tx_empty),
    .tx_rd(tx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_wr(rx_wr),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int pops = 0;
  int pushes = 0;
  int done_cnt = 0;
  int hi_cnt = 0;
  logic cs_h1 = 1'b1, cs_h2 = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_done = 1'b0;

  logic [31:0] tx_q[$];
  logic [31:0] pend_tx[$];
  bit          exp_mosi[$];
  string       exp_tag[$];
  bit          miso_q[$];
  logic [31:0] exp_rx[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // transmit FIFO model, show-ahead
  always @(negedge clk) begin
    if (tx_rd) begin
      check(tx_q.size() > 0, "R4", 0, 1);
      if (tx_q.size() > 0) void'(tx_q.pop_front());
      pops++;
    end
    tx_empty = (tx_q.size() == 0);
    tx_data  = tx_empty ? 32'h0 : tx_q[0];
  end

  // receive monitor
  always @(negedge clk) begin
    if (rx_wr) begin
      pushes++;
      if (exp_rx.size() == 0) check(1'b0, "R5", rx_data, 0);
      else begin
        logic [31:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R5", rx_data, e);
      end
    end
  end

  // slave model: presents next bit at select fall and at each SCLK fall
  always @(negedge sclk or negedge cs_n) begin
    if (miso_q.size() > 0) miso = miso_q.pop_front();
    else miso = 1'b0;
  end

  // MOSI scoreboard at each rising SCLK edge
  always @(posedge sclk) begin
    rise_cnt++;
    check(cs_n == 1'b0, "R1", cs_n, 0);
    if (exp_mosi.size() == 0) check(1'b0, "R1", rise_cnt, 0);
    else begin
      bit e;
      string t;
      e = exp_mosi.pop_front();
      t = exp_tag.pop_front();
      check(mosi == e, t, mosi, e);
    end
  end

  // timing monitor: SCLK width, MOSI steadiness, done placement
  always @(negedge clk) begin
    cyc++;
    if (sclk) hi_cnt++;
    else if (hi_cnt != 0) begin
      check(hi_cnt == CLK_DIV / 2, "R10", hi_cnt, CLK_DIV / 2);
      hi_cnt = 0;
    end
    if (sclk && prev_sclk && (mosi != prev_mosi)) check(1'b0, "R10", mosi, prev_mosi);
    if (done) begin
      done_cnt++;
      check(cs_n && cs_h1 && !cs_h2, "R9", {cs_n, cs_h1, cs_h2}, 3'b110);
      check(!prev_done, "R9", prev_done, 0);
    end
    cs_h2 = cs_h1; cs_h1 = cs_n;
    prev_sclk = sclk; prev_mosi = mosi; prev_done = done;
    if (cyc > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk_word(input int seed, input int w);
    return (32'(seed) * 32'h9E3779B1) ^ (32'(w) * 32'h01000193) ^ 32'hA5C3_0F17;
  endfunction

  task automatic prep(input int len, input int seed, input int ntx_now);
    int nwords = len / 32 + 1;
    int nb = len % 32 + 1;
    int k = 0;
    rise_cnt = 0; pops = 0; pushes = 0;
    for (int w = 0; w < nwords; w++) begin
      logic [31:0] word = mk_word(seed, w);
      logic [31:0] rxw = 32'h0;
      int top = (w == 0) ? nb - 1 : 31;
      if (w < ntx_now) tx_q.push_back(word);
      else pend_tx.push_back(word);
      for (int b = top; b >= 0; b--) begin
        bit mb = ((k * 5 + seed) % 3) == 0;
        exp_mosi.push_back(word[b]);
        exp_tag.push_back((w == 0) ? "R2" : "R3");
        miso_q.push_back(mb);
        rxw = {rxw[30:0], mb};
        k++;
      end
      exp_rx.push_back(rxw);
    end
  endtask

  task automatic fire(input int len);
    @(negedge clk);
    burst_len = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic finish_checks(input int len);
    int nwords = len / 32 + 1;
    check(rise_cnt == len + 1, "R1", rise_cnt, len + 1);
    check(pops == nwords, "R4", pops, nwords);
    check(pushes == nwords, "R5", pushes, nwords);
    check(exp_mosi.size() == 0, "R3", exp_mosi.size(), 0);
    check(exp_rx.size() == 0, "R5", exp_rx.size(), 0);
  endtask

  task automatic burst(input int len, input int seed);
    prep(len, seed, len / 32 + 1);
    fire(len);
    wait_done();
    finish_checks(len);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check(cs_n == 1'b1, "R11", cs_n, 1);
    check(sclk == 1'b0, "R11", sclk, 0);
    check({done, busy, tx_rd, rx_wr} == 4'b0, "R11", {done, busy, tx_rd, rx_wr}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    burst(0, 1);     // single bit
    burst(7, 2);     // 8 low bits of one word
    burst(31, 3);    // one full word
    burst(32, 4);    // 1 bit then a full word
    burst(69, 5);    // 6 bits then two full words

    // R6: transmit FIFO starved after the first word
    prep(63, 6, 1);
    fire(63);
    repeat (300) @(negedge clk);
    check(rise_cnt == 32, "R6", rise_cnt, 32);
    check(cs_n == 1'b0, "R6", cs_n, 0);
    check(sclk == 1'b0, "R6", sclk, 0);
    while (pend_tx.size() > 0) tx_q.push_back(pend_tx.pop_front());
    wait_done();
    finish_checks(63);
    repeat (5) @(negedge clk);

    // R7: receive FIFO full during the first word
    rx_full = 1'b1;
    prep(40, 7, 2);
    fire(40);
    repeat (250) @(negedge clk);
    check(rise_cnt == 9, "R7", rise_cnt, 9);
    check(pushes == 0, "R7", pushes, 0);
    check(cs_n == 1'b0, "R7", cs_n, 0);
    rx_full = 1'b0;
    wait_done();
    finish_checks(40);
    repeat (5) @(negedge clk);

    // R8: start during a burst is ignored
    prep(50, 8, 2);
    fire(50);
    repeat (20) @(negedge clk);
    fire(5);
    wait_done();
    check(rise_cnt == 51, "R8", rise_cnt, 51);
    finish_checks(50);
    repeat (60) @(negedge clk);
    check(cs_n == 1'b1 && rise_cnt == 51, "R8", rise_cnt, 51);

    // longest burst: 128 full words
    burst(4095, 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule